// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block sits at the home node of a small shared-memory system and keeps a directory of which nodes hold copies of each cached block. A tracked block is either shared (one or more readers) or exclusive (a single owner that may have modified it). A block with no directory entry is uncached. Requesting nodes send read-miss and write requests over one request channel. The controller answers each request either from memory or by telling a caching node to forward its copy. It also sends invalidations to nodes whose copies have become stale.

Every accepted request starts a memory read in the same cycle that the directory lookup begins. When the lookup finds a read whose block is already held by another node, the controller sends a directed probe to one holder. That holder's cache supplies the data, and the memory result for that request is discarded by its transaction tag. A write invalidates every other holder and leaves the writer as the sole exclusive owner. When a set of the directory is full, an existing entry is evicted. Every holder of the evicted block is invalidated, and an exclusive victim also produces a writeback. The new request waits until every invalidation has been acknowledged.

The controller handles one transaction at a time. The memory port is assumed always ready, and its responses carry back the tag of the read they answer.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, no probe, response or writeback is asserted, and the directory is empty, so the first access to any address is served from memory.
- R2: In the cycle a request is accepted, `mem_rd_valid` is 1 with `mem_rd_addr` equal to the request address. `mem_rd_tag` starts at 0 after reset and increases by one (mod 2^TW) per accepted request.
- R3: A read that misses the directory is served from memory (`rsp_from_cache`=0), with no probe. The block is then shared, with the requester as its only holder. A read that hits an entry whose only holder is the requester is also served from memory, with no probe.
- R4: A read that hits a block held by at least one other node sends exactly one directed probe (`prb_inv`=0) to the lowest-numbered other holder, with `prb_addr` set to the block and `prb_dest` set to the requester. The response has `rsp_from_cache`=1 and comes in the cycle that holder raises `fwd_ack`. The block becomes shared, and the requester is added as a holder.
- R5: A memory response whose tag is not that of the current transaction is ignored. A memory-served response comes in the later of two cycles: the cycle the current tag returns, and the cycle after the last awaited invalidate acknowledgement (at the earliest, the cycle after the lookup).
- R6: A write that hits sends an invalidate (`prb_inv`=1) to every other holder in the lookup cycle and responds from memory only after all of them have acknowledged. Afterwards the writer is the sole exclusive holder. With no other holder, no probe is sent.
- R7: The address splits into a set index, the low log2(SETS) bits, and a tag, the remaining upper bits. A miss allocates the lowest-numbered free way of its set, as a write (exclusive) or as a read (shared).
- R8: A miss to a full set evicts the way named by that set's round-robin pointer. The pointer starts at 0 and advances by one per eviction. Every holder of the victim receives an invalidate at the victim's address. If the victim was exclusive, `mem_wb_valid` pulses with the victim address in the same cycle.
- R9: `req_ready` is 0 from the cycle after acceptance until the response cycle and returns to 1 in the cycle after it. Only one transaction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_node | input | log2(NODES) | Requesting node |
| req_addr | input | AW | Block address |
| req_write | input | 1 | 1 = write, 0 = read miss |
| mem_rd_valid | output | 1 | Memory read issued |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_tag | output | TW | Transaction tag of the read |
| mem_rsp_valid | input | 1 | Memory read data returned |
| mem_rsp_tag | input | TW | Tag of the returned read |
| mem_wb_valid | output | 1 | Writeback of an evicted exclusive block |
| mem_wb_addr | output | AW | Writeback address |
| prb_valid | output | NODES | Per-node probe or invalidate strobe |
| prb_inv | output | 1 | 1 = invalidate, 0 = directed forward probe |
| prb_addr | output | AW | Block the probe refers to |
| prb_dest | output | log2(NODES) | Node that receives forwarded data |
| inv_ack | input | NODES | Per-node invalidate acknowledgement |
| fwd_ack | input | NODES | Per-node forward-done acknowledgement |
| rsp_valid | output | 1 | Transaction completes, data delivered |
| rsp_node | output | log2(NODES) | Node being answered |
| rsp_from_cache | output | 1 | 1 = data came from a cache, 0 = from memory |

## Verification
The bench aims at a late memory response from a forwarded read. That response lands inside the next, memory-served transaction. A controller that did not compare tags would answer that transaction several cycles early, with the wrong data. Holder sets that include the requester check that the probe goes to the lowest other holder and never back to the requester. Probing the requester, or the highest holder, shows up as a wrong strobe vector. Evictions are driven into full sets twice, once with a shared victim and once with an exclusive one. A controller with a wrong round-robin pointer, a missing writeback, or one that did not wait for staggered acknowledgements shows a wrong victim address, a missing pulse or an early response.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NODES = 4,
  parameter int AW    = 12,
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [$clog2(NODES)-1:0] req_node,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  output logic             mem_rd_valid,
  output logic [AW-1:0]    mem_rd_addr,
  output logic [TW-1:0]    mem_rd_tag,
  input  logic             mem_rsp_valid,
  input  logic [TW-1:0]    mem_rsp_tag,
  output logic             mem_wb_valid,
  output logic [AW-1:0]    mem_wb_addr,
  output logic [NODES-1:0] prb_valid,
  output logic             prb_inv,
  output logic [AW-1:0]    prb_addr,
  output logic [$clog2(NODES)-1:0] prb_dest,
  input  logic [NODES-1:0] inv_ack,
  input  logic [NODES-1:0] fwd_ack,
  output logic             rsp_valid,
  output logic [$clog2(NODES)-1:0] rsp_node,
  output logic             rsp_from_cache
);
  localparam int NW = $clog2(NODES);
  localparam int SW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);
  localparam int GW = AW - SW;

  typedef enum logic [2:0] {IDLE, LOOK, PROBE, INV, EVICT, MEMW} st_t;

  st_t             st;
  logic [NW-1:0]   r_node, pnode;
  logic [AW-1:0]   r_addr;
  logic            r_write, mem_got;
  logic [TW-1:0]   tag_ctr, cur_tag;
  logic [NODES-1:0] pend;
  logic [WW-1:0]   way_q;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  ex_q  [SETS];
  logic [GW-1:0]    tag_q [SETS][WAYS];
  logic [NODES-1:0] sh_q  [SETS][WAYS];
  logic [WW-1:0]    rr_q  [SETS];

  logic [SW-1:0]    s;
  logic [GW-1:0]    gtag;
  logic             hit, has_free;
  logic [WW-1:0]    hway, fway, vict;
  logic [NODES-1:0] req_bit, others, vsh, pend_left;
  logic [NW-1:0]    low;
  logic [AW-1:0]    vaddr;
  logic             accept, mem_now, look, do_fwd, do_winv, do_evict;

  assign s       = r_addr[SW-1:0];
  assign gtag    = r_addr[AW-1:SW];
  assign req_bit = NODES'(1) << r_node;
  assign vict    = rr_q[s];
  assign vsh     = sh_q[s][vict];
  assign vaddr   = {tag_q[s][vict], s};

  always_comb begin
    hit = 1'b0; hway = '0; has_free = 1'b0; fway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[s][w] && tag_q[s][w] == gtag) begin
        hit = 1'b1; hway = WW'(w);
      end
      if (!vld_q[s][w]) begin
        has_free = 1'b1; fway = WW'(w);
      end
    end
  end

  assign others = sh_q[s][hway] & ~req_bit;

  always_comb begin
    low = '0;
    for (int n = NODES - 1; n >= 0; n--)
      if (others[n]) low = NW'(n);
  end

  assign accept    = req_valid && req_ready;
  assign mem_now   = mem_rsp_valid && mem_rsp_tag == cur_tag;
  assign look      = st == LOOK;
  assign do_fwd    = look && hit && !r_write && |others;
  assign do_winv   = look && hit && r_write && |others;
  assign do_evict  = look && !hit && !has_free;
  assign pend_left = pend & ~inv_ack;

  assign req_ready    = st == IDLE;
  assign mem_rd_valid = accept;
  assign mem_rd_addr  = req_addr;
  assign mem_rd_tag   = tag_ctr;
  assign mem_wb_valid = do_evict && ex_q[s][vict];
  assign mem_wb_addr  = vaddr;
  assign prb_valid    = do_fwd ? (NODES'(1) << low) : do_winv ? others : do_evict ? vsh : '0;
  assign prb_inv      = do_winv || do_evict;
  assign prb_addr     = do_evict ? vaddr : r_addr;
  assign prb_dest     = r_node;
  assign rsp_valid      = (st == PROBE && fwd_ack[pnode]) || (st == MEMW && (mem_got || mem_now));
  assign rsp_node       = r_node;
  assign rsp_from_cache = st == PROBE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; tag_ctr <= '0; cur_tag <= '0; mem_got <= 1'b0;
      pend <= '0; way_q <= '0; pnode <= '0;
      r_node <= '0; r_addr <= '0; r_write <= 1'b0;
      for (int i = 0; i < SETS; i++) begin
        vld_q[i] <= '0; ex_q[i] <= '0; rr_q[i] <= '0;
      end
    end else begin
      if (st == IDLE) mem_got <= 1'b0;
      else if (mem_now) mem_got <= 1'b1;
      case (st)
        IDLE: if (accept) begin
          r_node <= req_node; r_addr <= req_addr; r_write <= req_write;
          cur_tag <= tag_ctr; tag_ctr <= tag_ctr + 1'b1;
          st <= LOOK;
        end
        LOOK: begin
          if (hit) begin
            if (r_write) begin
              ex_q[s][hway] <= 1'b1;
              sh_q[s][hway] <= req_bit;
              pend <= others;
              st <= (|others) ? INV : MEMW;
            end else begin
              sh_q[s][hway] <= sh_q[s][hway] | req_bit;
              if (|others) ex_q[s][hway] <= 1'b0;
              pnode <= low;
              st <= (|others) ? PROBE : MEMW;
            end
          end else if (has_free) begin
            vld_q[s][fway] <= 1'b1;
            ex_q[s][fway]  <= r_write;
            tag_q[s][fway] <= gtag;
            sh_q[s][fway]  <= req_bit;
            st <= MEMW;
          end else begin
            way_q <= vict;
            rr_q[s] <= vict + 1'b1;
            pend <= vsh;
            st <= EVICT;
          end
        end
        PROBE: if (fwd_ack[pnode]) st <= IDLE;
        INV: begin
          pend <= pend_left;
          if (pend_left == '0) st <= MEMW;
        end
        EVICT: begin
          pend <= pend_left;
          if (pend_left == '0) begin
            ex_q[s][way_q]  <= r_write;
            tag_q[s][way_q] <= gtag;
            sh_q[s][way_q]  <= req_bit;
            st <= MEMW;
          end
        end
        MEMW: if (mem_got || mem_now) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NODES = 4,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_wb_valid,
  input logic [NODES-1:0] prb_valid,
  input logic             prb_inv,
  input logic [$clog2(NODES)-1:0] prb_dest,
  input logic             rsp_valid
);
  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R9
  reopen_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
  // R9
  rsp_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R4
  single_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|prb_valid && !prb_inv) |-> $onehot(prb_valid));
  // R4
  no_self_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|prb_valid && !prb_inv) |-> !prb_valid[prb_dest]);
  // R8
  wb_with_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> (|prb_valid && prb_inv));
  // R1
  quiet_probe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NODES(NODES), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_wb_valid(mem_wb_valid), .prb_valid(prb_valid), .prb_inv(prb_inv),
  .prb_dest(prb_dest), .rsp_valid(rsp_valid)
);

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
  localparam int NODES = 4, AW = 12, SETS = 4, WAYS = 4, TW = 3, MEMLAT = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_node = 0;
  logic [AW-1:0] req_addr = 0;
  logic req_ready, mem_rd_valid, mem_wb_valid, prb_inv, rsp_valid, rsp_from_cache;
  logic [AW-1:0] mem_rd_addr, mem_wb_addr, prb_addr;
  logic [TW-1:0] mem_rd_tag;
  logic mem_rsp_valid = 0;
  logic [TW-1:0] mem_rsp_tag = 0;
  logic [NODES-1:0] prb_valid;
  logic [NODES-1:0] inv_ack = 0, fwd_ack = 0;
  logic [1:0] prb_dest, rsp_node;

  always #2 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .AW(AW), .SETS(SETS), .WAYS(WAYS), .TW(TW)) i_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_addr(req_addr), .req_write(req_write),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_tag(mem_rd_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .mem_wb_valid(mem_wb_valid), .mem_wb_addr(mem_wb_addr),
    .prb_valid(prb_valid), .prb_inv(prb_inv), .prb_addr(prb_addr), .prb_dest(prb_dest),
    .inv_ack(inv_ack), .fwd_ack(fwd_ack),
    .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_from_cache(rsp_from_cache));

  int checks = 0, errors = 0, cyc = 0, ntx = 0;
  bit done = 0;
  int mq_due[$];
  logic [TW-1:0] mq_tag[$];
  int inv_due[NODES];
  int fwd_due = -1, fwd_node = 0;

  bit mv[SETS][WAYS];
  bit mx[SETS][WAYS];
  int mt[SETS][WAYS];
  bit [NODES-1:0] ms[SETS][WAYS];
  int mrr[SETS];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1; cyc++;
    mem_rsp_valid = 0; mem_rsp_tag = 0;
    if (mq_due.size() > 0 && mq_due[0] == cyc) begin
      mem_rsp_valid = 1; mem_rsp_tag = mq_tag[0];
      mq_due.delete(0); mq_tag.delete(0);
    end
    for (int n = 0; n < NODES; n++) begin
      inv_ack[n] = (inv_due[n] == cyc);
      fwd_ack[n] = (fwd_due == cyc && fwd_node == n);
    end
  endtask

  task automatic model(input int node, input int set, input int t, input bit wr,
                       output bit [NODES-1:0] eprb, output bit einv, output int epaddr,
                       output bit ewb, output bit efwd, output string rq);
    int hw = -1, fw = -1, v;
    bit [NODES-1:0] oth;
    eprb = 0; einv = 0; epaddr = t * SETS + set; ewb = 0; efwd = 0; rq = "R3";
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (mv[set][w] && mt[set][w] == t) hw = w;
      if (!mv[set][w]) fw = w;
    end
    if (hw >= 0) begin
      oth = ms[set][hw] & ~(NODES'(1) << node);
      if (wr) begin
        rq = (oth != 0) ? "R6" : "R6 no-holder";
        eprb = oth; einv = 1;
        ms[set][hw] = NODES'(1) << node; mx[set][hw] = 1;
      end else if (oth != 0) begin
        rq = "R4";
        for (int n = NODES - 1; n >= 0; n--) if (oth[n]) eprb = NODES'(1) << n;
        efwd = 1; mx[set][hw] = 0;
        ms[set][hw] = ms[set][hw] | (NODES'(1) << node);
      end
    end else if (fw >= 0) begin
      rq = "R7";
      mv[set][fw] = 1; mt[set][fw] = t; mx[set][fw] = wr; ms[set][fw] = NODES'(1) << node;
    end else begin
      rq = "R8";
      v = mrr[set];
      eprb = ms[set][v]; einv = 1; epaddr = mt[set][v] * SETS + set; ewb = mx[set][v];
      mt[set][v] = t; mx[set][v] = wr; ms[set][v] = NODES'(1) << node;
      mrr[set] = (v + 1) % WAYS;
    end
  endtask

  task automatic txn(input int node, input int set, input int t, input bit wr);
    bit [NODES-1:0] eprb;
    bit einv, ewb, efwd, got;
    int epaddr, issue, lookc, last_ack, ersp, bad_ready;
    string rq;
    int addr = t * SETS + set;
    logic [TW-1:0] etag = TW'(ntx);
    ntx++;
    model(node, set, t, wr, eprb, einv, epaddr, ewb, efwd, rq);
    tick();
    req_valid = 1; req_node = 2'(node); req_addr = AW'(addr); req_write = wr;
    #2;
    chk(req_ready == 1, "R9 ready while idle", int'(req_ready), 1);
    chk(mem_rd_valid == 1 && mem_rd_addr == AW'(addr), "R2 parallel memory read addr",
        int'(mem_rd_addr), addr);
    chk(mem_rd_tag == etag, "R2 transaction tag", int'(mem_rd_tag), int'(etag));
    issue = cyc;
    mq_due.push_back(cyc + MEMLAT); mq_tag.push_back(mem_rd_tag);
    tick();
    req_valid = 0;
    #2;
    lookc = cyc;
    chk(prb_valid == eprb, {rq, " probe strobes"}, int'(prb_valid), int'(eprb));
    if (eprb != 0) begin
      chk(prb_inv == einv, {rq, " probe kind"}, int'(prb_inv), int'(einv));
      chk(prb_addr == AW'(epaddr), {rq, " probe address"}, int'(prb_addr), epaddr);
      chk(prb_dest == 2'(node), {rq, " probe dest"}, int'(prb_dest), node);
    end
    chk(mem_wb_valid == ewb, "R8 writeback strobe", int'(mem_wb_valid), int'(ewb));
    if (ewb) chk(mem_wb_addr == AW'(epaddr), "R8 writeback address", int'(mem_wb_addr), epaddr);
    for (int n = 0; n < NODES; n++) begin
      if (prb_valid[n] && prb_inv) inv_due[n] = cyc + 2 + n;
      if (prb_valid[n] && !prb_inv) begin fwd_due = cyc + 2; fwd_node = n; end
    end
    last_ack = -1;
    for (int n = 0; n < NODES; n++)
      if (eprb[n] && einv) last_ack = lookc + 2 + n;
    if (efwd) ersp = lookc + 2;
    else begin
      ersp = issue + MEMLAT;
      if (lookc + 1 > ersp) ersp = lookc + 1;
      if (last_ack + 1 > ersp) ersp = last_ack + 1;
    end
    got = 0; bad_ready = 0;
    for (int k = 0; k < 60 && !got; k++) begin
      tick(); #2;
      if (rsp_valid) got = 1;
      else if (req_ready) bad_ready++;
    end
    chk(got, {rq, " response seen"}, int'(got), 1);
    chk(cyc == ersp, {rq, "/R5 response cycle"}, cyc, ersp);
    chk(rsp_from_cache == efwd, {rq, " response source"}, int'(rsp_from_cache), int'(efwd));
    chk(rsp_node == 2'(node), {rq, " response node"}, int'(rsp_node), node);
    chk(bad_ready == 0, "R9 held while busy", bad_ready, 0);
  endtask

  initial begin
    for (int n = 0; n < NODES; n++) inv_due[n] = -1;
    for (int i = 0; i < SETS; i++) begin
      mrr[i] = 0;
      for (int w = 0; w < WAYS; w++) begin mv[i][w] = 0; mx[i][w] = 0; mt[i][w] = 0; ms[i][w] = 0; end
    end
    repeat (3) tick();
    rst_n = 1;
    #2;
    // R1 reset state
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    chk(prb_valid == 0 && rsp_valid == 0 && mem_wb_valid == 0 && mem_rd_valid == 0,
        "R1 quiet outputs", int'(prb_valid), 0);
    txn(1, 0, 1, 0);   // R1/R3 first access from memory
    txn(2, 0, 1, 0);   // R4 forward from node 1
    txn(3, 1, 5, 0);   // R5 stale tag arrives during this one
    txn(1, 0, 1, 0);   // R3 sole-holder case not: holders 1,2 -> probe node 2
    txn(0, 0, 1, 0);   // R4 lowest other holder
    txn(3, 0, 1, 1);   // R6 invalidate 0,1,2 staggered acks
    txn(0, 0, 1, 0);   // R6 writer sole owner -> probe node 3
    txn(2, 2, 7, 1);   // R7 write miss, exclusive
    txn(2, 2, 7, 1);   // R6 owner rewrites, no probe
    txn(2, 0, 2, 1);   // R7 fill set 0
    txn(1, 0, 3, 0);
    txn(3, 0, 4, 0);
    txn(1, 0, 9, 0);   // R8 evict way 0, shared victim
    txn(1, 0, 10, 0);  // R8 evict way 1, exclusive victim -> writeback
    txn(0, 3, 3, 0);   // R3
    txn(0, 3, 3, 0);   // R3 sole holder read again, memory
    for (int i = 0; i < 40; i++)
      txn($urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(1, 6), ($urandom_range(0, 9) < 3));
    repeat (10) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule